// File: doc/BRIEF.md
# Byte Mailbox Between a Host Bus and a Coprocessor Bus

This block passes single bytes between an 8-bit host bus and a 32-bit coprocessor bus. Each direction has one byte register with its own flag. The inbound path, from host to coprocessor, has a pending flag. The outbound path, from coprocessor to host, has a ready flag. A third flag acts as an acknowledge: the coprocessor raises it and the host clears it by reading. Both sides can read a status byte that gathers the three flags and a reset-control bit. The host stops the coprocessor by writing that control bit from 1 to 0, which produces a one-cycle reset pulse. A free-running cycle counter is not cleared by that pulse.

On the host side the registers occupy a 4 KiB window. The window repeats in every bank whose bank bit 6 is zero, which covers banks 0x00 to 0x3F and 0x80 to 0xBF. On the coprocessor side the same registers appear in the region selected by address nibble 0x4. Both buses share one clock. Reads are combinational in the cycle of the strobe. Every flag and data update takes effect at the clock edge that ends the access.

Top module: `copro_mailbox_top`

## Requirements
- R1: The host window is hit (`host_hit`=1) only when host address bit 22 is 0 and bits 15:12 equal 0x3. That is offsets 0x3000 to 0x3FFF in banks 0x00 to 0x3F and 0x80 to 0xBF. Outside the window `host_hit` is 0, `host_rdata` is 0x00, and writes change no state.
- R2: A host read at window offset 0x800 returns the outbound byte in the same cycle. It clears the ready flag at that clock edge.
- R3: A host write at offset 0x802 stores the byte as the inbound byte and sets the pending flag. A coprocessor read of its data register returns that byte, zero-extended to 32 bits, and clears pending.
- R4: A coprocessor write to its acknowledge register sets the acknowledge flag. The flag holds until a host read at offset 0x802, which returns 0x00 and clears it.
- R5: The status byte has bit 0 = pending, bit 3 = ready, bit 4 = acknowledge and bit 7 = reset-control; all other bits are 0. After reset the status reads 0x80, `cp_reset` is 0 and the cycle counter is 0.
- R6: The coprocessor side is hit only when `cp_addr[31:28]` is 0x4. Inside that region `cp_addr[5:4]` selects the register: 0 is data (read the inbound byte, write the outbound byte), 1 is acknowledge (write only), 2 is status (read, zero-extended), and 3 reads 0. Other regions give `cp_hit`=0 and `cp_rdata`=0, and writes to them change no state.
- R7: A coprocessor write of its data register stores the outbound byte and sets ready. Writing either data byte while its flag is already set replaces the byte and leaves the flag set.
- R8: When a set and a clear of the same flag happen in the same cycle, the set wins. This holds for ready, pending and acknowledge alike.
- R9: A host write at offset 0x804 loads write-data bit 7 into the reset-control bit. Only a 1-to-0 change makes `cp_reset` high, for exactly the one cycle after that write's clock edge. The mailbox flags and bytes are not affected by that pulse.
- R10: `cp_cycle_cnt` increments on every clock. Only `rst` clears it; `cp_reset` does not.
- R11: Host reads at window offsets other than 0x800 and 0x804 return 0x00. Host writes at offsets other than 0x802 and 0x804 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 24 | Host address, bank in bits 23:16 |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| host_hit | output | 1 | Host address falls in the register window |
| cp_addr | input | 32 | Coprocessor address |
| cp_rd | input | 1 | Coprocessor read strobe |
| cp_wr | input | 1 | Coprocessor write strobe |
| cp_wdata | input | 8 | Coprocessor write byte lane |
| cp_rdata | output | 32 | Coprocessor read data, combinational |
| cp_hit | output | 1 | Coprocessor address falls in the mailbox region |
| cp_reset | output | 1 | One-cycle reset pulse to the coprocessor |
| cp_cycle_cnt | output | 32 | Free-running cycle counter |

## Verification
Every internal flag is visible in the status byte from both sides, so a wrong flag shows up on the first status read after the access that should have changed it. That read can come one cycle after the access. A wrong byte in either data register shows up on the next data read from the opposite port. A fault in the reset-control edge detector shows as a missing pulse, a second pulse, or a pulse on the wrong kind of write, one cycle after the write to the control register. A counter that is cleared by that pulse breaks the increment count measured across it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int HOST_AW   = 24;
    localparam int BYTE_W    = 8;
    localparam int CP_AW     = 32;
    localparam int CP_DW     = 32;
    localparam int CNT_W     = 32;

    localparam logic [3:0]  HOST_WIN_NIB  = 4'h3;
    localparam logic [3:0]  CP_REGION_NIB = 4'h4;

    localparam logic [11:0] OFF_OUTBOX = 12'h800;
    localparam logic [11:0] OFF_INBOX  = 12'h802;
    localparam logic [11:0] OFF_CTRL   = 12'h804;

    localparam int ST_PENDING = 0;
    localparam int ST_READY   = 3;
    localparam int ST_ACK     = 4;
    localparam int ST_CTL     = 7;
    localparam int CTL_WBIT   = 7;

    typedef enum logic [1:0] {
        HR_NONE   = 2'd0,
        HR_OUTBOX = 2'd1,
        HR_INBOX  = 2'd2,
        HR_CTRL   = 2'd3
    } host_reg_e;

    typedef enum logic [1:0] {
        CR_DATA = 2'd0,
        CR_ACK  = 2'd1,
        CR_STAT = 2'd2,
        CR_NONE = 2'd3
    } cp_reg_e;

    typedef struct packed {
        logic rd_outbox;
        logic wr_inbox;
        logic clr_ack;
        logic wr_ctrl;
    } host_ops_t;

    typedef struct packed {
        logic rd_inbox;
        logic wr_outbox;
        logic set_ack;
    } cp_ops_t;

    typedef struct packed {
        logic pending;
        logic ready;
        logic ack;
        logic ctl;
    } mbx_flags_t;

    function automatic logic [BYTE_W-1:0] pack_status(input mbx_flags_t f);
        logic [BYTE_W-1:0] s;
        s             = '0;
        s[ST_PENDING] = f.pending;
        s[ST_READY]   = f.ready;
        s[ST_ACK]     = f.ack;
        s[ST_CTL]     = f.ctl;
        return s;
    endfunction

    function automatic host_reg_e host_offset_to_reg(input logic [11:0] off);
        case (off)
            OFF_OUTBOX: return HR_OUTBOX;
            OFF_INBOX:  return HR_INBOX;
            OFF_CTRL:   return HR_CTRL;
            default:    return HR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
    import mbx_pkg::*;
#(
    parameter int         AW      = HOST_AW,
    parameter logic [3:0] WIN_NIB = HOST_WIN_NIB
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output logic          hit,
    output host_reg_e     sel,
    output host_ops_t     ops
);

    localparam int BANK_LSB = AW - 8;

    logic unused_bank_bits;
    assign unused_bank_bits = ^{addr[AW-1], addr[AW-3:BANK_LSB]};

    always_comb begin
        hit = (addr[AW-2] == 1'b0) && (addr[15:12] == WIN_NIB);
        sel = hit ? host_offset_to_reg(addr[11:0]) : HR_NONE;
        ops.rd_outbox = rd && (sel == HR_OUTBOX);
        ops.wr_inbox  = wr && (sel == HR_INBOX);
        ops.clr_ack   = rd && (sel == HR_INBOX);
        ops.wr_ctrl   = wr && (sel == HR_CTRL);
    end

endmodule

// File: rtl/mbx_cp_decode.sv
module mbx_cp_decode
    import mbx_pkg::*;
#(
    parameter int         AW     = CP_AW,
    parameter logic [3:0] REGION = CP_REGION_NIB
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output logic          hit,
    output cp_reg_e       sel,
    output cp_ops_t       ops
);

    logic unused_cp_bits;
    assign unused_cp_bits = ^{addr[AW-5:6], addr[3:0]};

    always_comb begin
        hit = (addr[AW-1:AW-4] == REGION);
        sel = hit ? cp_reg_e'(addr[5:4]) : CR_NONE;
        ops.rd_inbox  = rd && (sel == CR_DATA);
        ops.wr_outbox = wr && (sel == CR_DATA);
        ops.set_ack   = wr && (sel == CR_ACK);
    end

endmodule

// File: rtl/mbx_core.sv
module mbx_core
    import mbx_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  host_ops_t     h_ops,
    input  logic [DW-1:0] h_wdata,
    input  cp_ops_t       c_ops,
    input  logic [DW-1:0] c_wdata,
    output logic [DW-1:0] inbox_q,
    output logic [DW-1:0] outbox_q,
    output logic          pending_q,
    output logic          ready_q,
    output logic          ack_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            inbox_q   <= '0;
            outbox_q  <= '0;
            pending_q <= 1'b0;
            ready_q   <= 1'b0;
            ack_q     <= 1'b0;
        end else begin
            if (h_ops.wr_inbox) begin
                inbox_q   <= h_wdata;
                pending_q <= 1'b1;
            end else if (c_ops.rd_inbox) begin
                pending_q <= 1'b0;
            end

            if (c_ops.wr_outbox) begin
                outbox_q <= c_wdata;
                ready_q  <= 1'b1;
            end else if (h_ops.rd_outbox) begin
                ready_q  <= 1'b0;
            end

            if (c_ops.set_ack) begin
                ack_q <= 1'b1;
            end else if (h_ops.clr_ack) begin
                ack_q <= 1'b0;
            end
        end
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        h_ops.wr_inbox |=> pending_q && (inbox_q == $past(h_wdata))); // R3
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
        (c_ops.rd_inbox && !h_ops.wr_inbox) |=> !pending_q); // R3
    AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
        c_ops.wr_outbox |=> ready_q && (outbox_q == $past(c_wdata))); // R7
    AST_READY_CLR: assert property (@(posedge clk) disable iff (rst)
        (h_ops.rd_outbox && !c_ops.wr_outbox) |=> !ready_q); // R2
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !h_ops.clr_ack) |=> ack_q); // R4
    AST_ACK_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        c_ops.set_ack |=> ack_q); // R8

endmodule

// File: rtl/mbx_reset_ctl.sv
module mbx_reset_ctl
    import mbx_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          ctl_wbit,
    output logic          ctl_q,
    output logic          cp_reset,
    output logic [CW-1:0] cycle_cnt
);

    logic falling;
    assign falling = wr_ctrl && ctl_q && !ctl_wbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= 1'b1;
            cp_reset <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctl_q <= ctl_wbit;
            end
            cp_reset <= falling;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_cnt <= '0;
        end else begin
            cycle_cnt <= cycle_cnt + 1'b1;
        end
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cp_reset |=> !cp_reset); // R9
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cp_reset |-> ($past(wr_ctrl) && $past(ctl_q) && !ctl_q)); // R9
    AST_CTL_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctl_q)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cycle_cnt == $past(cycle_cnt) + 1'b1)); // R10

endmodule

// File: rtl/copro_mailbox_top.sv
module copro_mailbox_top
    import mbx_pkg::*;
#(
    parameter int H_AW = HOST_AW,
    parameter int C_AW = CP_AW,
    parameter int C_DW = CP_DW,
    parameter int CW   = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [H_AW-1:0]   host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_hit,
    input  logic [C_AW-1:0]   cp_addr,
    input  logic              cp_rd,
    input  logic              cp_wr,
    input  logic [BYTE_W-1:0] cp_wdata,
    output logic [C_DW-1:0]   cp_rdata,
    output logic              cp_hit,
    output logic              cp_reset,
    output logic [CW-1:0]     cp_cycle_cnt
);

    localparam int PAD_W = C_DW - BYTE_W;

    host_reg_e         h_sel;
    host_ops_t         h_ops;
    cp_reg_e           c_sel;
    cp_ops_t           c_ops;
    logic [BYTE_W-1:0] inbox_q;
    logic [BYTE_W-1:0] outbox_q;
    logic              pending_q;
    logic              ready_q;
    logic              ack_q;
    logic              ctl_q;
    mbx_flags_t        flags;
    logic [BYTE_W-1:0] status;

    mbx_host_decode #(.AW(H_AW)) u_hdec (
        .addr (host_addr),
        .rd   (host_rd),
        .wr   (host_wr),
        .hit  (host_hit),
        .sel  (h_sel),
        .ops  (h_ops)
    );

    mbx_cp_decode #(.AW(C_AW)) u_cdec (
        .addr (cp_addr),
        .rd   (cp_rd),
        .wr   (cp_wr),
        .hit  (cp_hit),
        .sel  (c_sel),
        .ops  (c_ops)
    );

    mbx_core #(.DW(BYTE_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .h_ops     (h_ops),
        .h_wdata   (host_wdata),
        .c_ops     (c_ops),
        .c_wdata   (cp_wdata),
        .inbox_q   (inbox_q),
        .outbox_q  (outbox_q),
        .pending_q (pending_q),
        .ready_q   (ready_q),
        .ack_q     (ack_q)
    );

    mbx_reset_ctl #(.CW(CW)) u_rctl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (h_ops.wr_ctrl),
        .ctl_wbit  (host_wdata[CTL_WBIT]),
        .ctl_q     (ctl_q),
        .cp_reset  (cp_reset),
        .cycle_cnt (cp_cycle_cnt)
    );

    always_comb begin
        flags.pending = pending_q;
        flags.ready   = ready_q;
        flags.ack     = ack_q;
        flags.ctl     = ctl_q;
        status        = pack_status(flags);
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (h_sel)
                HR_OUTBOX: host_rdata = outbox_q;
                HR_CTRL:   host_rdata = status;
                default:   host_rdata = '0;
            endcase
        end
    end

    always_comb begin
        cp_rdata = '0;
        if (cp_rd) begin
            case (c_sel)
                CR_DATA: cp_rdata = {{PAD_W{1'b0}}, inbox_q};
                CR_STAT: cp_rdata = {{PAD_W{1'b0}}, status};
                default: cp_rdata = '0;
            endcase
        end
    end

    AST_HOST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !host_hit |-> (host_rdata == '0)); // R1
    AST_CP_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cp_hit |-> (cp_rdata == '0)); // R6
    AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr[11:0] == OFF_CTRL && host_hit) |->
            (host_rdata[6:5] == 2'b00 && host_rdata[2:1] == 2'b00)); // R5

endmodule

// File: tb/copro_mailbox_top_bench.sv
module copro_mailbox_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] host_addr;
    logic        host_rd, host_wr;
    logic [7:0]  host_wdata, host_rdata;
    logic        host_hit;
    logic [31:0] cp_addr;
    logic        cp_rd, cp_wr;
    logic [7:0]  cp_wdata;
    logic [31:0] cp_rdata;
    logic        cp_hit, cp_reset;
    logic [31:0] cp_cycle_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0]  s_hrd;
    logic        s_hhit;
    logic [31:0] s_crd;
    logic        s_chit;

    always #2 clk = ~clk;

    copro_mailbox_top u_copro_mailbox_top (
        .clk (clk), .rst (rst),
        .host_addr (host_addr), .host_rd (host_rd), .host_wr (host_wr),
        .host_wdata (host_wdata), .host_rdata (host_rdata), .host_hit (host_hit),
        .cp_addr (cp_addr), .cp_rd (cp_rd), .cp_wr (cp_wr),
        .cp_wdata (cp_wdata), .cp_rdata (cp_rdata), .cp_hit (cp_hit),
        .cp_reset (cp_reset), .cp_cycle_cnt (cp_cycle_cnt)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        host_addr = '0; host_rd = 0; host_wr = 0; host_wdata = '0;
        cp_addr = '0; cp_rd = 0; cp_wr = 0; cp_wdata = '0;
    endtask

    // One bus cycle on both ports; called and returns at a falling edge.
    task automatic cyc(input logic [23:0] ha, input logic hr, input logic hw, input logic [7:0] hwd,
                       input logic [31:0] ca, input logic cr, input logic cw, input logic [7:0] cwd);
        host_addr = ha; host_rd = hr; host_wr = hw; host_wdata = hwd;
        cp_addr = ca; cp_rd = cr; cp_wr = cw; cp_wdata = cwd;
        #1;
        s_hrd = host_rdata; s_hhit = host_hit; s_crd = cp_rdata; s_chit = cp_hit;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic hrd(input logic [23:0] a);
        cyc(a, 1, 0, 8'h00, 32'h0, 0, 0, 8'h00);
    endtask
    task automatic hwr(input logic [23:0] a, input logic [7:0] d);
        cyc(a, 0, 1, d, 32'h0, 0, 0, 8'h00);
    endtask
    task automatic crd(input logic [31:0] a);
        cyc(24'h0, 0, 0, 8'h00, a, 1, 0, 8'h00);
    endtask
    task automatic cwr(input logic [31:0] a, input logic [7:0] d);
        cyc(24'h0, 0, 0, 8'h00, a, 0, 1, d);
    endtask
    task automatic status_is(input string req, input logic [7:0] exp);
        hrd(24'h003804);
        chk(req, "status", {24'h0, s_hrd}, {24'h0, exp});
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (3) @(negedge clk);
        chk("R5", "counter in reset", cp_cycle_cnt, 32'd0);
        chk("R5", "cp_reset in reset", {31'h0, cp_reset}, 32'd0);
        rst = 0;
        status_is("R5", 8'h80);
        chk("R5", "cp_reset after reset", {31'h0, cp_reset}, 32'd0);
    endtask

    task automatic t_host_decode();
        hrd(24'h803804);
        chk("R1", "hit bank 0x80", {31'h0, s_hhit}, 32'd1);
        chk("R1", "status via bank 0x80", {24'h0, s_hrd}, 32'h80);
        hrd(24'hBF3FFF);
        chk("R1", "hit bank 0xBF top offset", {31'h0, s_hhit}, 32'd1);
        chk("R11", "unused offset reads 0", {24'h0, s_hrd}, 32'h0);
        hrd(24'h403804);
        chk("R1", "no hit bank 0x40", {31'h0, s_hhit}, 32'd0);
        chk("R1", "miss reads 0", {24'h0, s_hrd}, 32'h0);
        hrd(24'h004804);
        chk("R1", "no hit offset 0x4804", {31'h0, s_hhit}, 32'd0);
        hwr(24'h403802, 8'h77);
        hwr(24'h002802, 8'h77);
        hwr(24'h003900, 8'h77);
        status_is("R1", 8'h80);
        crd(32'h4000_0000);
        chk("R11", "inbox untouched by ignored writes", s_crd, 32'h0);
    endtask

    task automatic t_inbox();
        hwr(24'h123802, 8'hA5);
        status_is("R3", 8'h81);
        crd(32'h4000_0000);
        chk("R3", "cp reads inbound", s_crd, 32'h0000_00A5);
        chk("R6", "cp hit region 4", {31'h0, s_chit}, 32'd1);
        status_is("R3", 8'h80);
        hwr(24'h003802, 8'h11);
        hwr(24'h003802, 8'h22);
        status_is("R7", 8'h81);
        crd(32'h4000_0000);
        chk("R7", "inbound overwritten", s_crd, 32'h22);
    endtask

    task automatic t_outbox();
        cwr(32'h4000_0000, 8'h3C);
        status_is("R7", 8'h88);
        cwr(32'h4000_0000, 8'h5A);
        status_is("R7", 8'h88);
        hrd(24'h8A3800);
        chk("R2", "host reads outbound", {24'h0, s_hrd}, 32'h5A);
        status_is("R2", 8'h80);
    endtask

    task automatic t_ack();
        cwr(32'h4000_0010, 8'h00);
        status_is("R4", 8'h90);
        status_is("R4", 8'h90);
        hrd(24'h003802);
        chk("R4", "ack clear read data", {24'h0, s_hrd}, 32'h0);
        status_is("R4", 8'h80);
    endtask

    task automatic t_cp_decode();
        crd(32'h4000_0020);
        chk("R6", "cp status", s_crd, 32'h80);
        crd(32'h5000_0000);
        chk("R6", "no hit region 5", {31'h0, s_chit}, 32'd0);
        chk("R6", "miss reads 0", s_crd, 32'h0);
        cwr(32'hA000_0000, 8'h99);
        cwr(32'h0000_0010, 8'h99);
        status_is("R6", 8'h80);
        crd(32'h4000_0030);
        chk("R6", "unused cp reg reads 0", s_crd, 32'h0);
        chk("R6", "unused cp reg hit", {31'h0, s_chit}, 32'd1);
    endtask

    task automatic t_simul();
        cwr(32'h4000_0000, 8'h01);
        cyc(24'h003800, 1, 0, 8'h00, 32'h4000_0000, 0, 1, 8'h02);
        chk("R8", "host got old byte", {24'h0, s_hrd}, 32'h01);
        status_is("R8", 8'h88);
        hrd(24'h003800);
        chk("R8", "new outbound byte kept", {24'h0, s_hrd}, 32'h02);
        hwr(24'h003802, 8'h03);
        cyc(24'h003802, 0, 1, 8'h04, 32'h4000_0000, 1, 0, 8'h00);
        chk("R8", "cp got old inbound", s_crd, 32'h03);
        status_is("R8", 8'h81);
        crd(32'h4000_0000);
        cyc(24'h003802, 1, 0, 8'h00, 32'h4000_0010, 0, 1, 8'h00);
        status_is("R8", 8'h90);
        hrd(24'h003802);
        status_is("R8", 8'h80);
    endtask

    task automatic t_reset_ctl();
        logic [31:0] c0;
        hwr(24'h003802, 8'h5C);
        c0 = cp_cycle_cnt;
        hwr(24'h003804, 8'h80);
        chk("R9", "no pulse on 1->1", {31'h0, cp_reset}, 32'd0);
        hwr(24'h003804, 8'h7F);
        chk("R9", "pulse after 1->0", {31'h0, cp_reset}, 32'd1);
        @(negedge clk);
        chk("R9", "pulse lasts one cycle", {31'h0, cp_reset}, 32'd0);
        chk("R10", "counter not cleared by cp_reset", cp_cycle_cnt, c0 + 32'd3);
        status_is("R9", 8'h01);
        hwr(24'h003804, 8'h00);
        chk("R9", "no pulse on 0->0", {31'h0, cp_reset}, 32'd0);
        hwr(24'h003804, 8'h80);
        chk("R9", "no pulse on 0->1", {31'h0, cp_reset}, 32'd0);
        status_is("R9", 8'h81);
        crd(32'h4000_0000);
        chk("R9", "inbound byte survives pulse", s_crd, 32'h5C);
        c0 = cp_cycle_cnt;
        repeat (10) @(negedge clk);
        chk("R10", "counter steps per clock", cp_cycle_cnt, c0 + 32'd10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; idle();
        @(negedge clk);
        t_reset();
        t_host_decode();
        t_inbox();
        t_outbox();
        t_ack();
        t_cp_decode();
        t_simul();
        t_reset_ctl();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule